// File: doc/BRIEF.md
# Four-Way Read-Only Word Cache with Stamp-Based Replacement

This block sits between a requester that only reads 32-bit words and a slower backing memory. The cache has eight sets. Each set holds four ways, and each way holds one word. On every request the block picks a set from the middle address bits. It then compares the upper address bits against the tags of all four ways at once. A hit returns the stored word one cycle after the request is accepted, and no memory traffic is generated.

On a miss, the block stops accepting requests. It issues a single word fetch to the backing memory and waits for the reply. When the reply arrives, the block installs the word and returns it to the requester on the following cycle.

Replacement uses recency stamps taken from a free-running count of accepted requests. A way that is touched, whether by a hit or by a fill, records the count value at the moment its request was accepted. When a miss needs a way, an empty way is used first. If every way in the set is valid, the way with the smallest stamp is replaced.

Top module: `sa_read_cache`

## Requirements
- R1: Address bits [4:2] select the set and bits [31:5] form the tag. Bits [1:0] have no effect on the lookup or on the returned word.
- R2: A request that finds a valid way with a matching tag is a hit. The cycle after acceptance, resp_valid and resp_hit are 1, resp_miss is 0, resp_data holds the cached word, and mem_req_valid stays 0.
- R3: On a miss, from the cycle after acceptance until mem_resp_valid is seen, mem_req_valid is 1 and mem_req_addr holds the request address with bits [1:0] cleared. During this time req_ready is 0 and resp_valid is 0.
- R4: The cycle after mem_resp_valid is sampled high during a fetch, resp_valid and resp_miss are 1, resp_hit is 0, and resp_data equals the fetched word. req_ready returns to 1 in that same cycle. A later request to the same word hits.
- R5: A miss fills the lowest-numbered invalid way of its set, if the set has one.
- R6: When all four ways of a set are valid, a miss replaces the way with the smallest stamp. A hit refreshes the stamp of the way it hits, which protects that way from the next eviction.
- R7: A reference count starts at zero and rises by one for each accepted request, hit or miss. The hit or fill caused by a request stores the count value at that request's acceptance. Equal stamps resolve to the lowest way number.
- R8: After reset, every way is invalid, so the first access to any address misses. At reset, req_ready is 1 and both resp_valid and mem_req_valid are 0.
- R9: resp_hit and resp_miss are never 1 together, and neither is 1 unless resp_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the requested word |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_data | output | 32 | Returned word |
| resp_hit | output | 1 | Response was served from the cache |
| resp_miss | output | 1 | Response was served by a fetch |
| mem_req_valid | output | 1 | Fetch to backing memory pending |
| mem_req_addr | output | 32 | Word-aligned fetch address |
| mem_resp_valid | input | 1 | Backing memory reply strobe |
| mem_resp_data | input | 32 | Backing memory reply word |

## Verification
The bench builds the block with its default parameters: eight sets, four ways, 32-bit address and data, and a 16-bit stamp. With these values, a few thousand requests never wrap the stamp. The random phase draws tags from a pool of six per set, so sets fill, overflow and evict often. This means both empty-way filling and oldest-stamp eviction are reached many times. Directed sequences pin down one exact eviction order and show that the low two address bits are ignored.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  typedef enum logic [0:0] {
    ST_LOOKUP = 1'b0,
    ST_FETCH  = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/sa_line_store.sv
module sa_line_store #(
  parameter int SETS    = 8,
  parameter int WAYS    = 4,
  parameter int TAG_W   = 27,
  parameter int DATA_W  = 32,
  parameter int STAMP_W = 16,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [IDX_W-1:0]                rd_set,
  output logic [WAYS-1:0]                 rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0]      rd_tag,
  output logic [WAYS-1:0][STAMP_W-1:0]    rd_stamp,
  output logic [WAYS-1:0][DATA_W-1:0]     rd_data,
  input  logic                            touch_en,
  input  logic [IDX_W-1:0]                touch_set,
  input  logic [WAY_W-1:0]                touch_way,
  input  logic [STAMP_W-1:0]              touch_stamp,
  input  logic                            fill_en,
  input  logic [IDX_W-1:0]                fill_set,
  input  logic [WAY_W-1:0]                fill_way,
  input  logic [TAG_W-1:0]                fill_tag,
  input  logic [DATA_W-1:0]               fill_data,
  input  logic [STAMP_W-1:0]              fill_stamp
);
  logic               valid_arr [SETS][WAYS];
  logic [TAG_W-1:0]   tag_arr   [SETS][WAYS];
  logic [STAMP_W-1:0] stamp_arr [SETS][WAYS];
  logic [DATA_W-1:0]  data_arr  [SETS][WAYS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic               fill_here, touch_here, stamp_en;
      logic [STAMP_W-1:0] stamp_nx;
      logic               v_q;
      logic [TAG_W-1:0]   t_q;
      logic [STAMP_W-1:0] s_q;
      logic [DATA_W-1:0]  d_q;

      always_comb begin
        fill_here  = fill_en  && (fill_set  == IDX_W'(s)) && (fill_way  == WAY_W'(w));
        touch_here = touch_en && (touch_set == IDX_W'(s)) && (touch_way == WAY_W'(w));
        stamp_en   = fill_here || touch_here;
        stamp_nx   = fill_here ? fill_stamp : touch_stamp;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         v_q <= 1'b0;
        else if (fill_here) v_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (fill_here) begin
          t_q <= fill_tag;
          d_q <= fill_data;
        end
        if (stamp_en) s_q <= stamp_nx;
      end

      assign valid_arr[s][w] = v_q;
      assign tag_arr[s][w]   = t_q;
      assign stamp_arr[s][w] = s_q;
      assign data_arr[s][w]  = d_q;
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_valid[w] = valid_arr[rd_set][w];
      rd_tag[w]   = tag_arr[rd_set][w];
      rd_stamp[w] = stamp_arr[rd_set][w];
      rd_data[w]  = data_arr[rd_set][w];
    end
  end

  // a touch and a fill are never issued together (lookup and fetch are exclusive)
  assert_one_write_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(touch_en && fill_en));
endmodule

// File: rtl/sa_tag_match.sv
module sa_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 27,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lookup_en,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
  end

  always_comb begin
    hit     = |hit_vec;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  // a tag lives in at most one way of a set
  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_en |-> $onehot0(hit_vec));
endmodule

// File: rtl/sa_victim_pick.sv
module sa_victim_pick #(
  parameter int WAYS    = 4,
  parameter int STAMP_W = 16,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pick_en,
  input  logic [WAYS-1:0]              way_valid,
  input  logic [WAYS-1:0][STAMP_W-1:0] way_stamp,
  output logic [WAY_W-1:0]             victim
);
  logic               found_empty;
  logic [WAY_W-1:0]   empty_way;
  logic [WAY_W-1:0]   oldest_way;
  logic [STAMP_W-1:0] oldest_stamp;

  always_comb begin
    found_empty = 1'b0;
    empty_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) begin
        found_empty = 1'b1;
        empty_way   = WAY_W'(w);
      end
    end
  end

  always_comb begin
    oldest_way   = '0;
    oldest_stamp = way_stamp[0];
    for (int w = 1; w < WAYS; w++) begin
      if (way_stamp[w] < oldest_stamp) begin
        oldest_way   = WAY_W'(w);
        oldest_stamp = way_stamp[w];
      end
    end
  end

  assign victim = found_empty ? empty_way : oldest_way;

  // with any empty way present, a valid way is never chosen
  assert_empty_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_en && !(&way_valid)) |-> !way_valid[victim]);
endmodule

// File: rtl/sa_read_cache.sv
module sa_read_cache #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SETS    = 8,
  parameter int WAYS    = 4,
  parameter int STAMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data
);
  import sa_cache_pkg::*;

  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  ctl_state_e state_q, state_d;

  logic [IDX_W-1:0]   req_set;
  logic [TAG_W-1:0]   req_tag;
  logic               accept, lookup_hit, fill_now;
  logic [WAY_W-1:0]   hit_way, victim_way;

  logic [WAYS-1:0]              set_valid;
  logic [WAYS-1:0][TAG_W-1:0]   set_tag;
  logic [WAYS-1:0][STAMP_W-1:0] set_stamp;
  logic [WAYS-1:0][DATA_W-1:0]  set_data;

  logic [STAMP_W-1:0] ref_cnt_q, ref_cnt_d;
  logic [IDX_W-1:0]   pend_set_q;
  logic [TAG_W-1:0]   pend_tag_q;
  logic [WAY_W-1:0]   pend_way_q;
  logic [STAMP_W-1:0] pend_stamp_q;
  logic               pend_en;

  logic               resp_valid_d, resp_hit_d, resp_miss_d;
  logic [DATA_W-1:0]  resp_data_d;

  logic unused_byte_bits;
  assign unused_byte_bits = ^req_addr[OFF_W-1:0];

  assign req_set = req_addr[OFF_W +: IDX_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  sa_line_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W), .STAMP_W(STAMP_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_set     (req_set),
    .rd_valid   (set_valid),
    .rd_tag     (set_tag),
    .rd_stamp   (set_stamp),
    .rd_data    (set_data),
    .touch_en   (accept && lookup_hit),
    .touch_set  (req_set),
    .touch_way  (hit_way),
    .touch_stamp(ref_cnt_q),
    .fill_en    (fill_now),
    .fill_set   (pend_set_q),
    .fill_way   (pend_way_q),
    .fill_tag   (pend_tag_q),
    .fill_data  (mem_resp_data),
    .fill_stamp (pend_stamp_q)
  );

  sa_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .lookup_en(accept),
    .way_valid(set_valid),
    .way_tag  (set_tag),
    .req_tag  (req_tag),
    .hit      (lookup_hit),
    .hit_way  (hit_way)
  );

  sa_victim_pick #(.WAYS(WAYS), .STAMP_W(STAMP_W)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .pick_en  (pend_en),
    .way_valid(set_valid),
    .way_stamp(set_stamp),
    .victim   (victim_way)
  );

  // control: next state
  always_comb begin
    accept    = req_valid && (state_q == ST_LOOKUP);
    fill_now  = (state_q == ST_FETCH) && mem_resp_valid;
    pend_en   = accept && !lookup_hit;
    ref_cnt_d = accept ? ref_cnt_q + 1'b1 : ref_cnt_q;
    state_d   = state_q;
    case (state_q)
      ST_LOOKUP: if (pend_en)  state_d = ST_FETCH;
      ST_FETCH:  if (fill_now) state_d = ST_LOOKUP;
      default:                 state_d = ST_LOOKUP;
    endcase
    resp_hit_d   = accept && lookup_hit;
    resp_miss_d  = fill_now;
    resp_valid_d = resp_hit_d || resp_miss_d;
    resp_data_d  = fill_now ? mem_resp_data : set_data[hit_way];
  end

  // control: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_LOOKUP;
      ref_cnt_q  <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_miss  <= 1'b0;
    end else begin
      state_q    <= state_d;
      ref_cnt_q  <= ref_cnt_d;
      resp_valid <= resp_valid_d;
      resp_hit   <= resp_hit_d;
      resp_miss  <= resp_miss_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_en) begin
      pend_set_q   <= req_set;
      pend_tag_q   <= req_tag;
      pend_way_q   <= victim_way;
      pend_stamp_q <= ref_cnt_q;
    end
    if (resp_valid_d) resp_data <= resp_data_d;
  end

  assign req_ready     = (state_q == ST_LOOKUP);
  assign mem_req_valid = (state_q == ST_FETCH);
  assign mem_req_addr  = {pend_tag_q, pend_set_q, {OFF_W{1'b0}}};

  assert_stall_on_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (!req_ready && !resp_valid));

  assert_fetch_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_resp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_fill_returns_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_resp_valid) |=>
      (resp_valid && resp_miss && req_ready && resp_data == $past(mem_resp_data)));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ref_cnt_q == STAMP_W'($past(ref_cnt_q) + 1'b1)));

  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid ? (resp_hit ^ resp_miss) : (!resp_hit && !resp_miss));
endmodule

// File: tb/sa_read_cache_tb.sv
`timescale 1ns/1ps
module sa_read_cache_tb;
  localparam int NSETS = 8;
  localparam int NWAYS = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_ready;
  logic        resp_valid;
  logic [31:0] resp_data;
  logic        resp_hit;
  logic        resp_miss;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_resp_valid;
  logic [31:0] mem_resp_data;

  always #2 clk = ~clk;

  sa_read_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_hit(resp_hit), .resp_miss(resp_miss),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
  );

  int checks = 0;
  int fails  = 0;

  bit          m_valid [NSETS][NWAYS];
  logic [26:0] m_tag   [NSETS][NWAYS];
  int unsigned m_stamp [NSETS][NWAYS];
  int unsigned m_cnt;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  function automatic void model_reset();
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin
        m_valid[s][w] = 1'b0;
        m_stamp[s][w] = 0;
        m_tag[s][w]   = '0;
      end
    m_cnt = 0;
  endfunction

  // returns expected hit flag and updates the reference state
  function automatic bit model_access(input logic [31:0] a);
    int s = int'(a[4:2]);
    int vic = -1;
    int unsigned best;
    for (int w = 0; w < NWAYS; w++)
      if (m_valid[s][w] && m_tag[s][w] == a[31:5]) begin
        m_stamp[s][w] = m_cnt;
        m_cnt++;
        return 1'b1;
      end
    for (int w = NWAYS - 1; w >= 0; w--)
      if (!m_valid[s][w]) vic = w;
    if (vic < 0) begin
      vic  = 0;
      best = m_stamp[s][0];
      for (int w = 1; w < NWAYS; w++)
        if (m_stamp[s][w] < best) begin
          vic  = w;
          best = m_stamp[s][w];
        end
    end
    m_valid[s][vic] = 1'b1;
    m_tag[s][vic]   = a[31:5];
    m_stamp[s][vic] = m_cnt;
    m_cnt++;
    return 1'b0;
  endfunction

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge with the response checked
  task automatic do_access(input string req, input logic [31:0] a, input int delay);
    bit exp_hit = model_access(a);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = 32'($urandom);
    check_eq(req, "hit flag", {31'b0, resp_hit}, {31'b0, exp_hit});
    if (exp_hit) begin
      check_eq({req, " R2"}, "hit response", {29'b0, resp_valid, resp_miss, mem_req_valid}, 32'b100);
      check_eq({req, " R2"}, "hit data", resp_data, mem_word(a));
    end else begin
      check_eq({req, " R3"}, "fetch pending", {29'b0, mem_req_valid, req_ready, resp_valid}, 32'b100);
      check_eq({req, " R3"}, "fetch addr", mem_req_addr, {a[31:2], 2'b00});
      for (int i = 0; i < delay; i++) begin
        @(negedge clk);
        check_eq({req, " R3"}, "fetch held", {30'b0, mem_req_valid, req_ready}, 32'b10);
      end
      mem_resp_valid = 1'b1;
      mem_resp_data  = mem_word(a);
      @(negedge clk);
      mem_resp_valid = 1'b0;
      mem_resp_data  = 32'($urandom);
      check_eq({req, " R4"}, "miss response",
               {28'b0, resp_valid, resp_miss, resp_hit, req_ready}, 32'b1101);
      check_eq({req, " R4"}, "miss data", resp_data, mem_word(a));
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int set, input int lo);
    return {27'(tag), 3'(set), 2'(lo)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    mem_resp_valid = 1'b0;
    mem_resp_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R8", "reset outputs", {29'b0, req_ready, resp_valid, mem_req_valid}, 32'b100);

    // R8: cold cache misses; R5: four fills use ways in order
    for (int t = 1; t <= 4; t++) do_access("R8 R5 cold fill", mk(t, 0, 0), 1);
    // R1: low byte bits ignored -> hit on same word
    do_access("R1 byte bits", mk(1, 0, 3), 0);
    // R6 R7: refresh tag1, then new tag5 must evict tag2 (oldest)
    do_access("R6 R7 evict", mk(5, 0, 0), 2);
    do_access("R6 survivor", mk(1, 0, 0), 0);
    do_access("R6 survivor", mk(3, 0, 0), 0);
    do_access("R6 survivor", mk(4, 0, 0), 0);
    do_access("R6 new line", mk(5, 0, 0), 0);
    do_access("R6 evicted", mk(2, 0, 0), 0);
    // R1: same tag, other set is independent
    do_access("R1 set select", mk(1, 5, 0), 3);
    do_access("R1 set select", mk(1, 5, 2), 0);
    // R5: after reset, refill goes through empty ways again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    do_access("R8 after reset", mk(1, 0, 0), 0);
    do_access("R5 refill", mk(9, 0, 0), 0);
    do_access("R5 refill", mk(1, 0, 1), 0);

    // mixed random traffic with a small tag pool per set
    for (int n = 0; n < 3000; n++)
      do_access("R5 R6 R7 R9 random",
                mk(int'($urandom % 6), int'($urandom % NSETS), int'($urandom % 4)),
                int'($urandom % 4));

    @(negedge clk);
    check_eq("R9", "idle flags", {29'b0, resp_valid, resp_hit, resp_miss}, 32'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule